// File: doc/BRIEF.md
# Single-Wire Sensor Bus Host Transaction Controller

This block is the register front end and transaction sequencer of a host on a single-wire processor sensor bus. Software programs a target address, a data byte count, a read byte count and a command code. It fills a write-data FIFO and sets the start bit. The block then works out the length field that goes on the wire from the command's class. It hands the header, the command and the write bytes one at a time to a byte-level link layer, and can append a hardware-computed frame check byte for write-type commands.

After the write phase, the link returns the target's frame check byte, which is compared with the host's own. The requested read bytes follow, with their own check byte, and they land in a read-data FIFO. The outcome is recorded as sticky write-one-to-clear status bits and a level interrupt. Bus faults reported by the link, or bus contention when that abort is enabled, end the transaction at once and lock out further starts until the host is disabled and enabled again.

Top module: `swire_host_ctrl`

## Requirements
- R1: After reset, the status and control registers read 0, irq is low and tx_valid is low.
- R2: A write of the control register (offset 0) with bit 0 (start) and bit 3 (host enable) set starts a transaction only when the block is idle and no reset is pending. Status bit 0 (busy) reads 1 until the transaction ends. While tx_valid is high and tx_ready is low, tx_valid and tx_data hold.
- R3: The bytes go out in this order: address, wire length, read count, command, then data. For command 0x00 the wire length is 0 and no command or data byte follows. For 0xA5, 0xB5, 0x65 and 0xE5 it is the write count plus 2. For any other command it is the write count plus 1.
- R4: For a write-type command with control bit 1 set, the last write byte is a CRC-8 (polynomial 0x07, initial 0, MSB first) over all bytes sent before it. With bit 1 clear, that slot is taken from the write FIFO.
- R5: The first byte received after the write phase is compared with the CRC-8 over every byte sent. If it equals the bitwise complement of that CRC, status bit 7 (0x80) is set and the transaction ends without finishing. Any other mismatch sets bit 3 (0x08).
- R6: The read bytes (read count, at most 16) are pushed into the read FIFO in arrival order, and each read of offset 7 pops the oldest. The byte after them is compared with the CRC-8 over the read bytes; a mismatch sets bit 2 (0x04).
- R7: With control bit 4 set, a frame check mismatch ends the transaction at once without the finished bit. With bit 4 clear, the transaction continues and sets bit 1 (0x02, finished) at its end.
- R8: Status bits 7:1 are sticky and cleared by writing 1 to them at offset 1 (0xFE clears all). Busy cannot be written. irq is high while any of bits 7:1 is set.
- R9: link_bus_err during a transaction ends it and sets bit 6 (0x40); link_ext_err does the same with bit 5 (0x20). Starts are then ignored until the control register is written with bit 3 clear.
- R10: With control bit 2 set, link_contend during a transaction ends it with bit 6 set, and the same lockout applies. With bit 2 clear, link_contend has no effect.
- R11: The write FIFO holds 15 bytes and further pushes are dropped; the read FIFO holds 16. Popping an empty FIFO returns 0. Control bit 5 empties both FIFOs; it and bit 0 always read back 0.
- R12: Register offsets: 0 control, 1 status, 2 target address, 3 write count (a written value above 15 is held as 15), 4 read count (a written value above 16 is held as 16), 5 command, 6 write-FIFO push, 7 read-FIFO pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at offset 7) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Byte offered to the link |
| tx_data | output | 8 | Byte to the link |
| tx_ready | input | 1 | Link accepts the byte |
| rx_valid | input | 1 | Byte from the link |
| rx_data | input | 8 | Received byte |
| link_bus_err | input | 1 | Bus fault from the link |
| link_ext_err | input | 1 | Extended fault from the link |
| link_contend | input | 1 | Bus contention seen by the link |

## Verification
A corrupted byte index or sequencer state shows on tx_data within the same transaction, as a wrong wire length, a missing command byte or a misplaced check byte. A wrong running CRC turns a good target reply into a write or read check error in the status register, one cycle after the reply arrives. A stale FIFO pointer shows at the next pop of offset 7 as a reordered or non-zero byte. A lost lockout flag shows as link traffic after a start that should have been ignored.

// File: rtl/swh_pkg.sv
package swh_pkg;
    localparam int WFIFO_DEPTH = 15;
    localparam int RFIFO_DEPTH = 16;
    localparam int CW          = 5;

    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_STAT  = 3'd1;
    localparam logic [2:0] RA_TADDR = 3'd2;
    localparam logic [2:0] RA_WCNT  = 3'd3;
    localparam logic [2:0] RA_RCNT  = 3'd4;
    localparam logic [2:0] RA_CMD   = 3'd5;
    localparam logic [2:0] RA_WDATA = 3'd6;
    localparam logic [2:0] RA_RDATA = 3'd7;

    typedef enum logic [2:0] {
        S_IDLE, S_TX, S_RX_WFCS, S_RX_DATA, S_RX_RFCS
    } seq_state_e;

    typedef struct packed {
        logic [7:0]    addr;
        logic [7:0]    cmd;
        logic [3:0]    wcnt;
        logic [CW-1:0] rcnt;
        logic          hw_fcs;
        logic          cont_abort;
        logic          fcs_abort;
    } txn_cfg_t;

    typedef struct packed {
        logic fin;
        logic rd_fcs;
        logic wr_fcs;
        logic ext;
        logic bus;
        logic code;
    } seq_evt_t;

    function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] din);
        logic [7:0] c;
        c = crc ^ din;
        for (int i = 0; i < 8; i++) begin
            c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic is_write_cmd(input logic [7:0] cmd);
        return (cmd == 8'hA5) || (cmd == 8'hB5) || (cmd == 8'h65) || (cmd == 8'hE5);
    endfunction

    function automatic logic [7:0] wire_len(input logic [7:0] cmd, input logic [3:0] n);
        if (cmd == 8'h00)      return 8'd0;
        if (is_write_cmd(cmd)) return {4'd0, n} + 8'd2;
        return {4'd0, n} + 8'd1;
    endfunction
endpackage

// File: rtl/swh_fifo.sv
module swh_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [NW-1:0] cnt;
    logic          full, do_push, do_pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == NW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            cnt <= cnt + NW'(do_push) - NW'(do_pop);
        end
    end

    a_r11_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= NW'(DEPTH));
    a_r11_pop_empty: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> empty);
endmodule

// File: rtl/swh_seq.sv
module swh_seq
    import swh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  txn_cfg_t   cfg,
    input  logic [7:0] wf_data,
    output logic       wf_pop,
    output logic       rf_push,
    output logic [7:0] rf_data,
    output logic       busy,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       bus_err,
    input  logic       ext_err,
    input  logic       contend,
    output seq_evt_t   evt
);
    seq_state_e    st;
    txn_cfg_t      cfg_q;
    logic [7:0]    wlen_q, crc_q, rcrc_q;
    logic [4:0]    idx;
    logic [CW-1:0] ridx;
    logic [4:0]    tx_last;
    logic          fcs_slot, from_fifo, abort_now;
    logic          w_seen, w_code, w_bad, r_seen, r_bad;

    assign busy      = (st != S_IDLE);
    assign tx_valid  = (st == S_TX);
    assign tx_last   = 5'd2 + wlen_q[4:0];
    assign abort_now = busy && (bus_err || ext_err || (cfg_q.cont_abort && contend));

    always_comb begin
        fcs_slot  = cfg_q.hw_fcs && is_write_cmd(cfg_q.cmd) && (idx == tx_last);
        from_fifo = (idx >= 5'd4) && !fcs_slot;
        case (idx)
            5'd0:    tx_data = cfg_q.addr;
            5'd1:    tx_data = wlen_q;
            5'd2:    tx_data = {{(8-CW){1'b0}}, cfg_q.rcnt};
            5'd3:    tx_data = cfg_q.cmd;
            default: tx_data = fcs_slot ? crc_q : wf_data;
        endcase
    end

    assign wf_pop  = tx_valid && tx_ready && from_fifo;
    assign rf_push = (st == S_RX_DATA) && rx_valid && !abort_now;
    assign rf_data = rx_data;

    assign w_seen = (st == S_RX_WFCS) && rx_valid && !abort_now;
    assign w_code = w_seen && (rx_data == ~crc_q);
    assign w_bad  = w_seen && (rx_data != crc_q) && !w_code;
    assign r_seen = (st == S_RX_RFCS) && rx_valid && !abort_now;
    assign r_bad  = r_seen && (rx_data != rcrc_q);

    always_comb begin
        evt.code   = w_code;
        evt.wr_fcs = w_bad;
        evt.rd_fcs = r_bad;
        evt.bus    = busy && (bus_err || (cfg_q.cont_abort && contend));
        evt.ext    = busy && ext_err;
        evt.fin    = (w_seen && !w_code && !(w_bad && cfg_q.fcs_abort) && (cfg_q.rcnt == '0))
                   || (r_seen && !(r_bad && cfg_q.fcs_abort));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cfg_q  <= '0;
            wlen_q <= '0;
            crc_q  <= '0;
            rcrc_q <= '0;
            idx    <= '0;
            ridx   <= '0;
        end else if (st == S_IDLE) begin
            if (go) begin
                cfg_q  <= cfg;
                wlen_q <= wire_len(cfg.cmd, cfg.wcnt);
                crc_q  <= '0;
                idx    <= '0;
                st     <= S_TX;
            end
        end else if (abort_now) begin
            st <= S_IDLE;
        end else begin
            case (st)
                S_TX: if (tx_ready) begin
                    crc_q <= crc8_step(crc_q, tx_data);
                    idx   <= idx + 1'b1;
                    if (idx == tx_last) st <= S_RX_WFCS;
                end
                S_RX_WFCS: if (rx_valid) begin
                    if (w_code || (w_bad && cfg_q.fcs_abort) || (cfg_q.rcnt == '0)) begin
                        st <= S_IDLE;
                    end else begin
                        st     <= S_RX_DATA;
                        rcrc_q <= '0;
                        ridx   <= '0;
                    end
                end
                S_RX_DATA: if (rx_valid) begin
                    rcrc_q <= crc8_step(rcrc_q, rx_data);
                    ridx   <= ridx + 1'b1;
                    if (ridx == cfg_q.rcnt - 1'b1) st <= S_RX_RFCS;
                end
                S_RX_RFCS: if (rx_valid) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    a_r2_tx_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !abort_now) |=> (tx_valid && $stable(tx_data)));
    a_r9_abort_idle: assert property (@(posedge clk) disable iff (rst)
        (busy && (bus_err || ext_err)) |=> !busy);
endmodule

// File: rtl/swire_host_ctrl.sv
module swire_host_ctrl
    import swh_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       tx_valid,
    output logic [7:0] tx_data,
    input  logic       tx_ready,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       link_bus_err,
    input  logic       link_ext_err,
    input  logic       link_contend
);
    logic [4:1]    ctrl_q;
    logic [7:1]    stat_q;
    logic [7:0]    taddr_q, cmd_q;
    logic [3:0]    wcnt_q;
    logic [CW-1:0] rcnt_q;
    logic          need_rst_q;

    logic          busy, go, fifo_clr, ctrl_we, stat_we;
    logic          wf_pop, rf_push, rf_empty, wf_empty_unused;
    logic [7:0]    wf_data, rf_data, rf_head;
    txn_cfg_t      cfg;
    seq_evt_t      ev;
    logic [7:1]    ev_bits;

    assign ctrl_we  = reg_wr && (reg_addr == RA_CTRL);
    assign stat_we  = reg_wr && (reg_addr == RA_STAT);
    assign fifo_clr = ctrl_we && reg_wdata[5];
    assign go       = ctrl_we && reg_wdata[0] && reg_wdata[3] && !busy && !need_rst_q;
    assign ev_bits  = {ev.code, ev.bus, ev.ext, 1'b0, ev.wr_fcs, ev.rd_fcs, ev.fin};
    assign irq      = |stat_q;

    always_comb begin
        cfg.addr       = taddr_q;
        cfg.cmd        = cmd_q;
        cfg.wcnt       = wcnt_q;
        cfg.rcnt       = rcnt_q;
        cfg.hw_fcs     = reg_wdata[1];
        cfg.cont_abort = reg_wdata[2];
        cfg.fcs_abort  = reg_wdata[4];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            stat_q     <= '0;
            taddr_q    <= '0;
            cmd_q      <= '0;
            wcnt_q     <= '0;
            rcnt_q     <= '0;
            need_rst_q <= 1'b0;
        end else begin
            if (ctrl_we) ctrl_q <= reg_wdata[4:1];
            if (reg_wr && reg_addr == RA_TADDR) taddr_q <= reg_wdata;
            if (reg_wr && reg_addr == RA_CMD)   cmd_q   <= reg_wdata;
            if (reg_wr && reg_addr == RA_WCNT)
                wcnt_q <= (reg_wdata > 8'd15) ? 4'd15 : reg_wdata[3:0];
            if (reg_wr && reg_addr == RA_RCNT)
                rcnt_q <= (reg_wdata > 8'd16) ? CW'(16) : reg_wdata[CW-1:0];
            stat_q <= (stat_q & ~(stat_we ? reg_wdata[7:1] : 7'd0) & 7'b1110111) | ev_bits;
            if (ev.bus || ev.ext)              need_rst_q <= 1'b1;
            else if (ctrl_we && !reg_wdata[3]) need_rst_q <= 1'b0;
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = {3'b000, ctrl_q, 1'b0};
            RA_STAT:  reg_rdata = {stat_q, busy};
            RA_TADDR: reg_rdata = taddr_q;
            RA_WCNT:  reg_rdata = {4'd0, wcnt_q};
            RA_RCNT:  reg_rdata = {{(8-CW){1'b0}}, rcnt_q};
            RA_CMD:   reg_rdata = cmd_q;
            RA_RDATA: reg_rdata = rf_head;
            default:  reg_rdata = 8'd0;
        endcase
    end

    swh_fifo #(.DEPTH(WFIFO_DEPTH), .W(8)) u_wfifo (
        .clk(clk), .rst(rst), .clr(fifo_clr),
        .push(reg_wr && reg_addr == RA_WDATA), .din(reg_wdata),
        .pop(wf_pop), .dout(wf_data), .empty(wf_empty_unused)
    );

    swh_fifo #(.DEPTH(RFIFO_DEPTH), .W(8)) u_rfifo (
        .clk(clk), .rst(rst), .clr(fifo_clr),
        .push(rf_push), .din(rf_data),
        .pop(reg_rd && reg_addr == RA_RDATA), .dout(rf_head), .empty(rf_empty)
    );

    swh_seq u_seq (
        .clk(clk), .rst(rst), .go(go), .cfg(cfg),
        .wf_data(wf_data), .wf_pop(wf_pop),
        .rf_push(rf_push), .rf_data(rf_data),
        .busy(busy), .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .bus_err(link_bus_err), .ext_err(link_ext_err), .contend(link_contend),
        .evt(ev)
    );

    a_r8_w1c_fin: assert property (@(posedge clk) disable iff (rst)
        (stat_we && reg_wdata[1] && !ev.fin) |=> !stat_q[1]);
    a_r9_start_blocked: assert property (@(posedge clk) disable iff (rst)
        (need_rst_q && ctrl_we && reg_wdata[0] && !busy) |=> !busy);
    a_r8_irq_src: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(busy));
    a_r11_rd_empty: assert property (@(posedge clk) disable iff (rst)
        rf_empty |-> (rf_head == 8'd0));
endmodule

// File: tb/swire_host_ctrl_tb.sv
module swire_host_ctrl_tb;
    logic       clk = 0, rst = 1;
    logic       reg_wr = 0, reg_rd = 0;
    logic [2:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       irq, tx_valid, tx_ready = 1;
    logic [7:0] tx_data;
    logic       rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic       link_bus_err = 0, link_ext_err = 0, link_contend = 0;

    int checks = 0, errors = 0;
    logic [7:0] txlog [1024];
    int txn = 0;
    bit stall = 0, inj_bus = 0, inj_ext = 0, inj_cont = 0;

    always #2 clk = ~clk;

    swire_host_ctrl u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .link_bus_err(link_bus_err), .link_ext_err(link_ext_err), .link_contend(link_contend)
    );

    always @(posedge clk) if (tx_valid && tx_ready && txn < 1024) begin
        txlog[txn] <= tx_data;
        txn <= txn + 1;
    end

    always @(negedge clk) begin
        tx_ready     = stall ? ~tx_ready : 1'b1;
        link_bus_err = inj_bus && tx_valid;
        link_ext_err = inj_ext && tx_valid;
        link_contend = inj_cont && tx_valid;
    end

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(4 * 190000);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] crc_add(input logic [7:0] c, input logic [7:0] d);
        logic fb;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ d[i];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic send_rx(input logic [7:0] b);
        @(negedge clk); rx_valid = 1; rx_data = b;
        @(negedge clk); rx_valid = 0;
    endtask

    // wmode: 0 good write check byte, 1 corrupted, 2 complemented
    task automatic txn_run(input string tag, input logic [7:0] cmd, input int n, input int r,
                           input logic [7:0] ctl, input int wmode, input bit rbad,
                           input int extra, input logic [7:0] exp_stat);
        logic [7:0] e [24];
        logic [7:0] c, v, rc;
        int ne, wl, slots, base, bad, pushes;
        bit wt, cont;
        wt = (cmd == 8'hA5) || (cmd == 8'hB5) || (cmd == 8'h65) || (cmd == 8'hE5);
        wl = (cmd == 8'h00) ? 0 : (wt ? n + 2 : n + 1);
        slots = (wl == 0) ? 0 : ((wt && ctl[1]) ? n : wl - 1);
        wr(3'd1, 8'hFE);
        wr(3'd0, 8'h28);
        pushes = ((slots > n) ? slots : n) + extra;
        for (int i = 0; i < pushes; i++) wr(3'd6, 8'h10 + 8'(i));
        wr(3'd2, 8'h30); wr(3'd3, 8'(n)); wr(3'd4, 8'(r)); wr(3'd5, cmd);
        e[0] = 8'h30; e[1] = 8'(wl); e[2] = 8'(r); ne = 3;
        if (wl > 0) begin e[3] = cmd; ne = 4; end
        for (int i = 0; i < slots; i++) begin e[ne] = 8'h10 + 8'(i); ne++; end
        if (wl > 0 && wt && ctl[1]) begin
            c = 8'h00;
            for (int i = 0; i < ne; i++) c = crc_add(c, e[i]);
            e[ne] = c; ne++;
        end
        base = txn;
        wr(3'd0, ctl | 8'h09);
        rd(3'd1, v);
        chk({tag, " R2 busy"}, v[0], 1);
        for (int k = 0; k < 400 && (txn - base) < ne; k++) @(negedge clk);
        bad = 0;
        for (int i = 0; i < ne; i++) if (txlog[base + i] !== e[i]) bad++;
        chk({tag, " R3 tx bytes"}, bad, 0);
        chk({tag, " R3 tx count"}, txn - base, ne);
        c = 8'h00;
        for (int i = 0; i < ne; i++) c = crc_add(c, e[i]);
        send_rx(wmode == 0 ? c : (wmode == 1 ? c ^ 8'h01 : ~c));
        cont = (wmode == 0) || (wmode == 1 && !ctl[4]);
        if (cont && r > 0) begin
            rc = 8'h00;
            for (int i = 0; i < r; i++) begin
                send_rx(8'hA0 + 8'(i));
                rc = crc_add(rc, 8'hA0 + 8'(i));
            end
            send_rx(rbad ? rc ^ 8'h80 : rc);
        end
        repeat (2) @(negedge clk);
        rd(3'd1, v);
        chk({tag, " R8 status"}, v, exp_stat);
        chk({tag, " R8 irq"}, irq, exp_stat[7:1] != 0);
        if (cont && r > 0) begin
            bad = 0;
            for (int i = 0; i < r; i++) begin
                rd(3'd7, v);
                if (v !== 8'hA0 + 8'(i)) bad++;
            end
            chk({tag, " R6 read order"}, bad, 0);
            rd(3'd7, v);
            chk({tag, " R11 empty pop"}, v, 0);
        end
    endtask

    task automatic t_abort(input string tag, input logic [7:0] ctl, input int which,
                           input logic [7:0] exp_stat);
        logic [7:0] v;
        int base;
        wr(3'd1, 8'hFE);
        wr(3'd2, 8'h30); wr(3'd3, 8'd0); wr(3'd4, 8'd0); wr(3'd5, 8'h01);
        inj_bus = (which == 0); inj_ext = (which == 1); inj_cont = (which == 2);
        wr(3'd0, ctl | 8'h09);
        repeat (8) @(negedge clk);
        inj_bus = 0; inj_ext = 0; inj_cont = 0;
        rd(3'd1, v);
        chk({tag, " status"}, v, exp_stat);
        chk({tag, " irq"}, irq, 1);
        wr(3'd1, 8'hFE);
        base = txn;
        wr(3'd0, 8'h09);
        repeat (4) @(negedge clk);
        rd(3'd1, v);
        chk({tag, " R9 start locked busy"}, v[0], 0);
        chk({tag, " R9 start locked link"}, txn - base, 0);
        wr(3'd0, 8'h00);
    endtask

    initial begin
        logic [7:0] v;
        int base;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        rd(3'd1, v); chk("R1 status", v, 0);
        rd(3'd0, v); chk("R1 control", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tx_valid", tx_valid, 0);
        // R12 register map and clamping
        wr(3'd3, 8'd20); rd(3'd3, v); chk("R12 wcnt clamp", v, 15);
        wr(3'd4, 8'd30); rd(3'd4, v); chk("R12 rcnt clamp", v, 16);
        wr(3'd2, 8'h5A); rd(3'd2, v); chk("R12 taddr", v, 8'h5A);
        wr(3'd0, 8'h3E); rd(3'd0, v); chk("R11 self-clear bits", v, 8'h1E);
        wr(3'd0, 8'h00);
        txn_run("R3 ping", 8'h00, 3, 0, 8'h00, 0, 0, 0, 8'h02);
        txn_run("R6 read", 8'h01, 0, 2, 8'h00, 0, 0, 0, 8'h02);
        txn_run("R4 hw fcs", 8'hA5, 2, 1, 8'h02, 0, 0, 0, 8'h02);
        txn_run("R4 sw slot", 8'h65, 1, 0, 8'h00, 0, 0, 0, 8'h02);
        txn_run("R3 plain", 8'hA1, 5, 4, 8'h00, 0, 0, 0, 8'h02);
        stall = 1;
        txn_run("R2 stall", 8'hB5, 3, 1, 8'h02, 0, 0, 0, 8'h02);
        stall = 0;
        txn_run("R11 full", 8'hE1, 15, 16, 8'h00, 0, 0, 5, 8'h02);
        txn_run("R5 wr bad", 8'h01, 0, 2, 8'h00, 1, 0, 0, 8'h0A);
        txn_run("R7 wr abort", 8'h01, 0, 2, 8'h10, 1, 0, 0, 8'h08);
        txn_run("R5 code", 8'h01, 0, 2, 8'h00, 2, 0, 0, 8'h80);
        txn_run("R6 rd bad", 8'h01, 0, 2, 8'h00, 0, 1, 0, 8'h06);
        txn_run("R7 rd abort", 8'h01, 0, 2, 8'h10, 0, 1, 0, 8'h04);
        // R8 write-one-to-clear of selected bits only
        wr(3'd1, 8'h02); rd(3'd1, v); chk("R8 partial w1c", v, 8'h04);
        wr(3'd1, 8'hFE); rd(3'd1, v); chk("R8 clear all", v, 0);
        chk("R8 irq low", irq, 0);
        t_abort("R9 bus", 8'h00, 0, 8'h40);
        txn_run("R9 after reset", 8'h00, 0, 0, 8'h00, 0, 0, 0, 8'h02);
        t_abort("R9 ext", 8'h00, 1, 8'h20);
        t_abort("R10 contend", 8'h04, 2, 8'h40);
        inj_cont = 1;
        txn_run("R10 contend off", 8'h01, 0, 1, 8'h00, 0, 0, 0, 8'h02);
        inj_cont = 0;
        // R11 clear bit empties the write FIFO
        wr(3'd1, 8'hFE);
        wr(3'd6, 8'h55); wr(3'd6, 8'h56);
        wr(3'd0, 8'h28);
        wr(3'd6, 8'h77);
        wr(3'd2, 8'h30); wr(3'd3, 8'd1); wr(3'd4, 8'd0); wr(3'd5, 8'hA1);
        base = txn;
        wr(3'd0, 8'h09);
        for (int k = 0; k < 100 && (txn - base) < 5; k++) @(negedge clk);
        chk("R11 fifo clear", txlog[base + 4], 8'h77);
        send_rx(8'h00);
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule